// File: doc/BRIEF.md
# Split Request Fragment Tracker

This block follows one memory access that has been cut into several fragments. It walks the access through three phases: address translation, sending packets to the data cache port, and collecting the responses. The block puts out one translation request per fragment. It then counts the translation results, which may come back in any order. Once every fragment has a result, it picks the lowest-numbered faulting fragment, if there is one. It then sends cache packets only for the fault-free fragments ahead of that point.

Packets go out one per cycle while the port accepts them. A refusal stops sending until the port signals a retry. When the number of responses equals the number of packets, the block raises a one-cycle completion pulse and returns to idle. If the owning instruction has been squashed at the moment translation finishes, the block drops the access without making a fault decision.

The state is visible as a 2-bit code: 0 idle, 1 translating, 2 request (no fault), 3 partial fault.

Top module: `frag_split_tracker`

## Requirements
- R1: After reset the state code is 0 and `xlat_req_o`, `pkt_valid_o`, `done_o` and `squash_o` are all low.
- R2: A `start_i` in idle with `nfrag_i` from 1 to MAX_FRAGS moves the state to 1 on the next cycle. The block then raises `xlat_req_o` for exactly `nfrag_i` consecutive cycles, with `xlat_idx_o` counting 0, 1, 2 and so on, and holds it low after that.
- R3: Translation results may arrive in any order. Translation is finished only when every index below `nfrag_i` has been reported. A repeated result for an index already reported is ignored, and so is a result with an index of `nfrag_i` or above. Neither one is counted, and neither one changes a stored fault code.
- R4: When translation finishes and every fragment's fault code is 0, the state becomes 2.
- R5: When translation finishes and some fault code is nonzero, the state becomes 3. `fault_idx_o` is then the lowest faulting index and `fault_code_o` is that fragment's code, whatever order the results arrived in. Both outputs read 0 outside state 3.
- R6: In state 3, packets are offered only for indices below `fault_idx_o`. In both states 2 and 3, packet indices go out in ascending order starting at 0.
- R7: A packet offered while `pkt_ready_i` is low is not counted as sent. `pkt_valid_o` then stays low until a `retry_i` pulse, after which the same index is offered again.
- R8: A new packet is offered only while responses received plus packets outstanding is below the packet count. Once every packet has been sent, `pkt_valid_o` stays low.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last response is registered, and the state is 0 in the following cycle. If the first fault is at index 0, there are no packets and `done_o` rises in the first cycle of state 3.
- R10: If `squashed_i` is high in the cycle translation finishes, `squash_o` pulses, the state returns to 0, and no packet is offered.
- R11: `start_i` has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin tracking a new split access |
| nfrag_i | input | CNT_W | Number of fragments, 1 to MAX_FRAGS |
| squashed_i | input | 1 | Owning instruction has been squashed |
| xlat_req_o | output | 1 | Translation request for one fragment |
| xlat_idx_o | output | IDX_W | Fragment index of the translation request |
| xlat_rsp_valid_i | input | 1 | A translation result is present |
| xlat_rsp_idx_i | input | IDX_W | Fragment index of the result |
| xlat_rsp_fault_i | input | FAULT_W | Fault code of the result, 0 means none |
| state_o | output | 2 | Tracker state code |
| fault_code_o | output | FAULT_W | Code of the first faulting fragment (state 3) |
| fault_idx_o | output | IDX_W | Index of the first faulting fragment (state 3) |
| pkt_valid_o | output | 1 | A cache packet is offered |
| pkt_idx_o | output | IDX_W | Fragment index of the offered packet |
| pkt_ready_i | input | 1 | Cache port accepts the offered packet |
| retry_i | input | 1 | Cache port may be tried again |
| pkt_rsp_i | input | 1 | One packet response has arrived |
| done_o | output | 1 | One-cycle completion pulse |
| squash_o | output | 1 | One-cycle pulse: access dropped at translation end |

## Verification
Four-fragment accesses are driven with results in scrambled order and with a late duplicate carrying a fault code. This separates counting distinct indices from counting raw results, and shows whether a late duplicate can overwrite a stored code. A three-fragment access has a high-index fault arriving before a lower one, plus an out-of-range index. This separates "lowest index" from "first to arrive" and shows whether the range filter works. A fault at index 0 exercises the zero-packet completion path, and a squash at the decision cycle exercises the abandon path. A port that refuses the first packet shows whether the block holds off until the retry and then offers the same index again, rather than skipping it or resending blindly.

// File: rtl/frag_pkg.sv
package frag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XLAT   = 2'd1,
        ST_REQ    = 2'd2,
        ST_PFAULT = 2'd3
    } trk_state_e;
endpackage

// File: rtl/frag_first_fault.sv
// Lowest-index nonzero fault code among NUM fragments.
module frag_first_fault #(
    parameter int NUM     = 4,
    parameter int FAULT_W = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM-1:0][FAULT_W-1:0] codes_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [FAULT_W-1:0]          code_o
);
    logic [NUM-1:0] nz;

    for (genvar g = 0; g < NUM; g++) begin : g_nz
        assign nz[g] = |codes_i[g];
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        code_o  = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (nz[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                code_o  = codes_i[i];
            end
        end
    end
endmodule

// File: rtl/frag_send_ctl.sv
// Packet issue window: offers index recvd+outstanding while below the count.
module frag_send_ctl #(
    parameter int CNT_W = 3,
    parameter int IDX_W = 2
) (
    input  logic [CNT_W-1:0] pkt_cnt_i,
    input  logic [CNT_W-1:0] recvd_i,
    input  logic [CNT_W-1:0] outst_i,
    input  logic             blocked_i,
    input  logic             ready_i,
    input  logic             retry_i,
    input  logic             rsp_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             all_rcvd_o,
    output logic [CNT_W-1:0] recvd_d_o,
    output logic [CNT_W-1:0] outst_d_o,
    output logic             blocked_d_o
);
    logic [CNT_W-1:0] next_idx;
    logic             take_rsp;
    logic             accepted;

    always_comb begin
        next_idx    = recvd_i + outst_i;
        all_rcvd_o  = (recvd_i == pkt_cnt_i);
        valid_o     = !all_rcvd_o && !blocked_i && (next_idx < pkt_cnt_i);
        idx_o       = next_idx[IDX_W-1:0];
        accepted    = valid_o && ready_i;
        take_rsp    = rsp_i && (outst_i != '0);
        recvd_d_o   = take_rsp ? recvd_i + 1'b1 : recvd_i;
        outst_d_o   = outst_i;
        if (accepted && !take_rsp) begin
            outst_d_o = outst_i + 1'b1;
        end else if (!accepted && take_rsp) begin
            outst_d_o = outst_i - 1'b1;
        end
        blocked_d_o = blocked_i;
        if (retry_i) begin
            blocked_d_o = 1'b0;
        end else if (valid_o && !ready_i) begin
            blocked_d_o = 1'b1;
        end
    end
endmodule

// File: rtl/frag_split_tracker.sv
module frag_split_tracker
    import frag_pkg::*;
#(
    parameter int MAX_FRAGS = 4,
    parameter int FAULT_W   = 4,
    localparam int CNT_W    = $clog2(MAX_FRAGS + 1),
    localparam int IDX_W    = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   nfrag_i,
    input  logic               squashed_i,
    output logic               xlat_req_o,
    output logic [IDX_W-1:0]   xlat_idx_o,
    input  logic               xlat_rsp_valid_i,
    input  logic [IDX_W-1:0]   xlat_rsp_idx_i,
    input  logic [FAULT_W-1:0] xlat_rsp_fault_i,
    output logic [1:0]         state_o,
    output logic [FAULT_W-1:0] fault_code_o,
    output logic [IDX_W-1:0]   fault_idx_o,
    output logic               pkt_valid_o,
    output logic [IDX_W-1:0]   pkt_idx_o,
    input  logic               pkt_ready_i,
    input  logic               retry_i,
    input  logic               pkt_rsp_i,
    output logic               done_o,
    output logic               squash_o
);
    typedef struct packed {
        trk_state_e                          st;
        logic [CNT_W-1:0]                    nfrag;
        logic [CNT_W-1:0]                    issued;
        logic [CNT_W-1:0]                    xlated;
        logic [MAX_FRAGS-1:0]                seen;
        logic [MAX_FRAGS-1:0][FAULT_W-1:0]   codes;
        logic [CNT_W-1:0]                    pkt_cnt;
        logic [CNT_W-1:0]                    outst;
        logic [CNT_W-1:0]                    recvd;
        logic                                blocked;
        logic [FAULT_W-1:0]                  fcode;
        logic [IDX_W-1:0]                    fidx;
    } trk_t;

    trk_t r_q, r_d;

    logic               ff_found;
    logic [IDX_W-1:0]   ff_idx;
    logic [FAULT_W-1:0] ff_code;

    logic               sc_valid;
    logic [IDX_W-1:0]   sc_idx;
    logic               sc_all;
    logic [CNT_W-1:0]   sc_recvd_d;
    logic [CNT_W-1:0]   sc_outst_d;
    logic               sc_blocked_d;

    logic               rsp_in_range;
    logic               start_ok;

    frag_first_fault #(
        .NUM     (MAX_FRAGS),
        .FAULT_W (FAULT_W),
        .IDX_W   (IDX_W)
    ) u_first (
        .codes_i (r_q.codes),
        .found_o (ff_found),
        .idx_o   (ff_idx),
        .code_o  (ff_code)
    );

    frag_send_ctl #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_send (
        .pkt_cnt_i   (r_q.pkt_cnt),
        .recvd_i     (r_q.recvd),
        .outst_i     (r_q.outst),
        .blocked_i   (r_q.blocked),
        .ready_i     (pkt_ready_i),
        .retry_i     (retry_i),
        .rsp_i       (pkt_rsp_i),
        .valid_o     (sc_valid),
        .idx_o       (sc_idx),
        .all_rcvd_o  (sc_all),
        .recvd_d_o   (sc_recvd_d),
        .outst_d_o   (sc_outst_d),
        .blocked_d_o (sc_blocked_d)
    );

    assign rsp_in_range = (CNT_W'(xlat_rsp_idx_i) < r_q.nfrag);
    assign start_ok     = start_i && (nfrag_i != '0) && (nfrag_i <= CNT_W'(MAX_FRAGS));

    always_comb begin
        r_d          = r_q;
        xlat_req_o   = 1'b0;
        xlat_idx_o   = r_q.issued[IDX_W-1:0];
        pkt_valid_o  = 1'b0;
        pkt_idx_o    = sc_idx;
        done_o       = 1'b0;
        squash_o     = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    r_d       = '0;
                    r_d.st    = ST_XLAT;
                    r_d.nfrag = nfrag_i;
                end
            end
            ST_XLAT: begin
                if (r_q.issued < r_q.nfrag) begin
                    xlat_req_o = 1'b1;
                    r_d.issued = r_q.issued + 1'b1;
                end
                if (xlat_rsp_valid_i && rsp_in_range && !r_q.seen[xlat_rsp_idx_i]) begin
                    r_d.seen[xlat_rsp_idx_i]  = 1'b1;
                    r_d.codes[xlat_rsp_idx_i] = xlat_rsp_fault_i;
                    r_d.xlated                = r_q.xlated + 1'b1;
                end
                if (r_q.xlated == r_q.nfrag) begin
                    if (squashed_i) begin
                        squash_o = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (ff_found) begin
                        r_d.st      = ST_PFAULT;
                        r_d.pkt_cnt = CNT_W'(ff_idx);
                        r_d.fcode   = ff_code;
                        r_d.fidx    = ff_idx;
                    end else begin
                        r_d.st      = ST_REQ;
                        r_d.pkt_cnt = r_q.nfrag;
                    end
                end
            end
            ST_REQ, ST_PFAULT: begin
                if (sc_all) begin
                    done_o = 1'b1;
                    r_d.st = ST_IDLE;
                end else begin
                    pkt_valid_o = sc_valid;
                    r_d.recvd   = sc_recvd_d;
                    r_d.outst   = sc_outst_d;
                    r_d.blocked = sc_blocked_d;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o      = r_q.st;
    assign fault_code_o = (r_q.st == ST_PFAULT) ? r_q.fcode : '0;
    assign fault_idx_o  = (r_q.st == ST_PFAULT) ? r_q.fidx  : '0;
endmodule

// File: rtl/frag_split_tracker_chk.sv
module frag_split_tracker_chk
    import frag_pkg::*;
#(
    parameter int IDX_W   = 2,
    parameter int FAULT_W = 4,
    parameter int CNT_W   = 3,
    parameter int MAX_FRAGS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [CNT_W-1:0]   nfrag_i,
    input logic [1:0]         state_o,
    input logic               xlat_req_o,
    input logic [FAULT_W-1:0] fault_code_o,
    input logic [IDX_W-1:0]   fault_idx_o,
    input logic               pkt_valid_o,
    input logic [IDX_W-1:0]   pkt_idx_o,
    input logic               pkt_ready_i,
    input logic               done_o,
    input logic               squash_o
);
    assert_start_enters_xlat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && start_i && nfrag_i != '0 && nfrag_i <= CNT_W'(MAX_FRAGS))
        |=> (state_o == ST_XLAT));

    assert_xlat_req_only_translating_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_o |-> (state_o == ST_XLAT));

    assert_fault_code_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PFAULT) |-> (fault_code_o != '0));

    assert_pkt_before_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PFAULT && pkt_valid_o) |-> (pkt_idx_o < fault_idx_o));

    assert_refusal_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_o && !pkt_ready_i && !done_o) |=> !pkt_valid_o);

    assert_done_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && state_o == ST_IDLE));

    assert_squash_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> (state_o == ST_IDLE && !pkt_valid_o));

    assert_start_ignored_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PFAULT && !done_o) |=> (state_o == ST_PFAULT || state_o == ST_IDLE));
endmodule

bind frag_split_tracker frag_split_tracker_chk #(
    .IDX_W     (IDX_W),
    .FAULT_W   (FAULT_W),
    .CNT_W     (CNT_W),
    .MAX_FRAGS (MAX_FRAGS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .nfrag_i      (nfrag_i),
    .state_o      (state_o),
    .xlat_req_o   (xlat_req_o),
    .fault_code_o (fault_code_o),
    .fault_idx_o  (fault_idx_o),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_idx_o    (pkt_idx_o),
    .pkt_ready_i  (pkt_ready_i),
    .done_o       (done_o),
    .squash_o     (squash_o)
);

// File: tb/sim_frag_split_tracker.sv
`timescale 1ns/1ps
module sim_frag_split_tracker;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [2:0] nfrag_i;
    logic       squashed_i;
    logic       xlat_req_o;
    logic [1:0] xlat_idx_o;
    logic       xlat_rsp_valid_i;
    logic [1:0] xlat_rsp_idx_i;
    logic [3:0] xlat_rsp_fault_i;
    logic [1:0] state_o;
    logic [3:0] fault_code_o;
    logic [1:0] fault_idx_o;
    logic       pkt_valid_o;
    logic [1:0] pkt_idx_o;
    logic       pkt_ready_i;
    logic       retry_i;
    logic       pkt_rsp_i;
    logic       done_o;
    logic       squash_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    frag_split_tracker u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic start_access(input int n);
        start_i = 1'b1;
        nfrag_i = 3'(n);
        step();
        start_i = 1'b0;
        chk("R2 state translating", state_o, 1);
        for (int i = 0; i < n; i++) begin
            chk("R2 xlat req", xlat_req_o, 1);
            chk("R2 xlat idx", xlat_idx_o, i);
            step();
        end
        chk("R2 xlat req stops", xlat_req_o, 0);
    endtask

    task automatic xlat_rsp(input int idx, input int code);
        xlat_rsp_valid_i = 1'b1;
        xlat_rsp_idx_i   = 2'(idx);
        xlat_rsp_fault_i = 4'(code);
        step();
        xlat_rsp_valid_i = 1'b0;
    endtask

    task automatic pkt_resp(input int count);
        for (int i = 0; i < count; i++) begin
            chk("R9 no done early", done_o, 0);
            pkt_rsp_i = 1'b1;
            step();
            pkt_rsp_i = 1'b0;
        end
        chk("R9 done pulse", done_o, 1);
        step();
        chk("R9 done one cycle", done_o, 0);
        chk("R9 back to idle", state_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 state", state_o, 0);
        chk("R1 xlat req", xlat_req_o, 0);
        chk("R1 pkt valid", pkt_valid_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 squash", squash_o, 0);
    endtask

    task automatic t_all_clean();
        start_access(4);
        xlat_rsp(2, 0);
        xlat_rsp(0, 0);
        xlat_rsp(3, 0);
        xlat_rsp(2, 7);
        chk("R3 duplicate not counted", state_o, 1);
        xlat_rsp(1, 0);
        chk("R10 no squash", squash_o, 0);
        step();
        chk("R4 request state", state_o, 2);
        chk("R3 duplicate code dropped", fault_code_o, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R6 pkt valid", pkt_valid_o, 1);
            chk("R6 pkt idx", pkt_idx_o, i);
            step();
        end
        chk("R8 no pkt past count", pkt_valid_o, 0);
        pkt_resp(4);
    endtask

    task automatic t_partial_fault();
        start_access(3);
        xlat_rsp(2, 5);
        xlat_rsp(3, 6);
        xlat_rsp(1, 9);
        chk("R3 out of range ignored", state_o, 1);
        xlat_rsp(0, 0);
        step();
        chk("R5 partial fault state", state_o, 3);
        chk("R5 first fault index", fault_idx_o, 1);
        chk("R5 first fault code", fault_code_o, 9);
        chk("R6 pkt idx0 offered", pkt_valid_o, 1);
        chk("R6 pkt idx0", pkt_idx_o, 0);
        start_i = 1'b1;
        nfrag_i = 3'd2;
        step();
        start_i = 1'b0;
        chk("R6 no pkt at fault", pkt_valid_o, 0);
        chk("R11 start ignored", state_o, 3);
        chk("R11 fault idx kept", fault_idx_o, 1);
        pkt_resp(1);
    endtask

    task automatic t_fault_at_zero();
        start_access(2);
        xlat_rsp(1, 0);
        xlat_rsp(0, 4);
        step();
        chk("R5 state fault", state_o, 3);
        chk("R5 idx zero", fault_idx_o, 0);
        chk("R5 code", fault_code_o, 4);
        chk("R6 no packet", pkt_valid_o, 0);
        chk("R9 immediate done", done_o, 1);
        step();
        chk("R9 idle after", state_o, 0);
        chk("R5 fault outputs cleared", fault_code_o, 0);
    endtask

    task automatic t_refusal();
        pkt_ready_i = 1'b0;
        start_access(4);
        xlat_rsp(3, 0);
        xlat_rsp(1, 0);
        xlat_rsp(0, 0);
        xlat_rsp(2, 0);
        step();
        chk("R4 request state", state_o, 2);
        chk("R7 first offer", pkt_valid_o, 1);
        chk("R7 first offer idx", pkt_idx_o, 0);
        step();
        pkt_ready_i = 1'b1;
        #1;
        chk("R7 blocked after refusal", pkt_valid_o, 0);
        step();
        chk("R7 still blocked", pkt_valid_o, 0);
        retry_i = 1'b1;
        step();
        retry_i = 1'b0;
        #1;
        for (int i = 0; i < 4; i++) begin
            chk("R7 resend valid", pkt_valid_o, 1);
            chk("R7 resend idx", pkt_idx_o, i);
            step();
        end
        chk("R8 all sent", pkt_valid_o, 0);
        pkt_resp(4);
    endtask

    task automatic t_squash();
        start_access(2);
        xlat_rsp(0, 0);
        xlat_rsp(1, 3);
        squashed_i = 1'b1;
        #1;
        chk("R10 squash pulse", squash_o, 1);
        step();
        squashed_i = 1'b0;
        #1;
        chk("R10 idle after squash", state_o, 0);
        chk("R10 no packet", pkt_valid_o, 0);
        chk("R10 squash single", squash_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start_i = 1'b0;
        nfrag_i = '0;
        squashed_i = 1'b0;
        xlat_rsp_valid_i = 1'b0;
        xlat_rsp_idx_i = '0;
        xlat_rsp_fault_i = '0;
        pkt_ready_i = 1'b1;
        retry_i = 1'b0;
        pkt_rsp_i = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_all_clean();
        t_partial_fault();
        t_fault_at_zero();
        t_refusal();
        t_squash();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule